// File: doc/BRIEF.md
# Raster Circle Test-Pattern Generator

This block draws a filled circle into a raster video stream. An existing timing generator supplies a frame-start strobe, a line-start strobe and a pixel-valid strobe. The circle is set by centre coordinates and by a squared radius that is already computed. For every valid pixel the block emits one bit, set when the pixel lies strictly inside the circle.

The block needs no multiplier and no square root. The squared distance to the centre is carried in two accumulators that are stepped by odd-number additions. A line accumulator advances once per line. A pixel accumulator is reloaded from it at each line start and then advances once per pixel. The two starting squares are built by a shift-add sequence during vertical blanking. Several circles can be drawn by instantiating several copies and OR-ing their outputs.

Coordinates follow the strobes. The row is the number of line starts since the last frame start, minus one. The column is the number of valid pixels since the last line start.

Top module: `circle_pattern_gen`

## Requirements
- R1: For a pixel in column x and row y, pix_on_o is 1 exactly when (x−cx)²+(y−cy)² is strictly less than the latched squared radius. A distance equal to the squared radius is dark.
- R2: pix_on_o is registered. It shows the result for a pixel in the clock after that pixel's pix_valid_i. In a clock that follows a cycle with pix_valid_i low, it is 0.
- R3: A squared radius of 0 lights no pixel, including the centre pixel.
- R4: cx_i, cy_i and rsq_i are sampled only in a frame_start_i cycle. Changing them later in the frame does not alter that frame's output.
- R5: The column count restarts at 0 on every line_start_i, so the horizontal distance term never carries from one line into the next.
- R6: Results stay exact for centres on or off the visible area and for coordinates up to the full COORD_W range. The 2·COORD_W+2 bit accumulators never wrap.
- R7: While rst_ni is low, and after its release until the first valid pixel, pix_on_o is 0.
- R8: After frame_start_i, the first line_start_i may come no sooner than COORD_W+3 clocks later. A new frame_start_i partway through a frame abandons the old frame, and the next frame is drawn with the new parameters only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-clock strobe that starts a frame and latches the parameters |
| line_start_i | input | 1 | One-clock strobe before the first pixel of each line |
| pix_valid_i | input | 1 | High for each active pixel |
| cx_i | input | COORD_W | Centre column |
| cy_i | input | COORD_W | Centre row |
| rsq_i | input | 2·COORD_W+2 | Squared radius, computed outside the block |
| pix_on_o | output | 1 | Pixel lies inside the circle, one clock after pix_valid_i |

## Verification
The assertions take the timing generator to be well behaved in three ways. No line or pixel strobe arrives while the starting squares are still being formed. A line start never shares a clock with a valid pixel. A line holds no more than 2^COORD_W pixels, so the horizontal offset grows without wrapping. The stimulus waits COORD_W+4 clocks after each frame start, puts an idle clock between a line start and its first pixel, and uses a 24×16 raster. With these timings every property stays within its stated conditions.

// File: rtl/circle_pkg.sv
package circle_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_e;
endpackage

// File: rtl/circle_sq_shift_add.sv
module circle_sq_shift_add
  import circle_pkg::*;
#(
  parameter int W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   operand_i,
  output logic [2*W-1:0] square_o,
  output logic           done_o
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam int P_W   = 2 * W;

  sq_state_e        state_q;
  logic [W-1:0]     op_q;
  logic [IDX_W-1:0] idx_q;
  logic [P_W-1:0]   acc_q;
  logic [P_W-1:0]   addend;

  // one partial product per clock
  always_comb begin
    addend = '0;
    if (op_q[idx_q]) addend = P_W'(op_q) << idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      op_q    <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
    end else if (start_i) begin
      state_q <= SQ_RUN;
      op_q    <= operand_i;
      idx_q   <= '0;
      acc_q   <= '0;
    end else begin
      case (state_q)
        SQ_RUN: begin
          acc_q <= acc_q + addend;
          if (idx_q == IDX_W'(W - 1)) state_q <= SQ_DONE;
          else                        idx_q   <= idx_q + 1'b1;
        end
        SQ_DONE: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign square_o = acc_q;
  assign done_o   = (state_q == SQ_DONE);
endmodule

// File: rtl/circle_dist_tracker.sv
module circle_dist_tracker #(
  parameter int W = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [2*W+1:0]        init_sum_i,
  input  logic [W-1:0]          cx_i,
  input  logic [W-1:0]          cy_i,
  input  logic                  line_start_i,
  input  logic                  pix_step_i,
  output logic [2*W+1:0]        pix_acc_o,
  output logic [2*W+1:0]        line_acc_o,
  output logic signed [W+1:0]   dx_o
);
  localparam int ACC_W  = 2 * W + 2;
  localparam int D_W    = W + 2;
  localparam int STEP_W = D_W + 1;

  logic [ACC_W-1:0]      line_acc_q, pix_acc_q;
  logic signed [D_W-1:0] dx_q, dy_q;
  logic                  first_line_q;
  logic [STEP_W-1:0]     step_x, step_y;
  logic [ACC_W-1:0]      step_x_ext, step_y_ext, next_line;

  // 2*d+1 in two's complement, widened to the accumulator
  assign step_x     = {dx_q, 1'b1};
  assign step_y     = {dy_q, 1'b1};
  assign step_x_ext = {{(ACC_W-STEP_W){step_x[STEP_W-1]}}, step_x};
  assign step_y_ext = {{(ACC_W-STEP_W){step_y[STEP_W-1]}}, step_y};
  assign next_line  = line_acc_q + step_y_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_acc_q   <= '0;
      pix_acc_q    <= '0;
      dx_q         <= '0;
      dy_q         <= '0;
      first_line_q <= 1'b1;
    end else if (load_i) begin
      line_acc_q   <= init_sum_i;
      dy_q         <= -$signed({2'b00, cy_i});
      first_line_q <= 1'b1;
    end else if (line_start_i) begin
      dx_q <= -$signed({2'b00, cx_i});
      if (first_line_q) begin
        pix_acc_q    <= line_acc_q;
        first_line_q <= 1'b0;
      end else begin
        line_acc_q <= next_line;
        pix_acc_q  <= next_line;
        dy_q       <= dy_q + 1'b1;
      end
    end else if (pix_step_i) begin
      pix_acc_q <= pix_acc_q + step_x_ext;
      dx_q      <= dx_q + 1'b1;
    end
  end

  assign pix_acc_o  = pix_acc_q;
  assign line_acc_o = line_acc_q;
  assign dx_o       = dx_q;
endmodule

// File: rtl/circle_pattern_gen.sv
module circle_pattern_gen #(
  parameter int COORD_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_start_i,
  input  logic                   line_start_i,
  input  logic                   pix_valid_i,
  input  logic [COORD_W-1:0]     cx_i,
  input  logic [COORD_W-1:0]     cy_i,
  input  logic [2*COORD_W+1:0]   rsq_i,
  output logic                   pix_on_o
);
  localparam int ACC_W = 2 * COORD_W + 2;
  localparam int SQ_W  = 2 * COORD_W;

  logic [COORD_W-1:0]         cx_q, cy_q;
  logic [ACC_W-1:0]           rsq_q;
  logic                       setup_q;
  logic [SQ_W-1:0]            sq_x, sq_y;
  logic                       done_x, done_y;
  logic [ACC_W-1:0]           init_sum;
  logic [ACC_W-1:0]           pix_acc, line_acc;
  logic signed [COORD_W+1:0]  dx;
  logic                       pix_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cx_q    <= '0;
      cy_q    <= '0;
      rsq_q   <= '0;
      setup_q <= 1'b0;
    end else if (frame_start_i) begin
      cx_q    <= cx_i;
      cy_q    <= cy_i;
      rsq_q   <= rsq_i;
      setup_q <= 1'b1;
    end else if (done_x) begin
      setup_q <= 1'b0;
    end
  end

  circle_sq_shift_add #(.W(COORD_W)) u_sq_x (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (frame_start_i),
    .operand_i (cx_i),
    .square_o  (sq_x),
    .done_o    (done_x)
  );

  circle_sq_shift_add #(.W(COORD_W)) u_sq_y (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (frame_start_i),
    .operand_i (cy_i),
    .square_o  (sq_y),
    .done_o    (done_y)
  );

  // both squarers run in lock step; done_y only kept for symmetry
  assign init_sum = ACC_W'(sq_x) + ACC_W'(sq_y);

  circle_dist_tracker #(.W(COORD_W)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (done_x & done_y),
    .init_sum_i   (init_sum),
    .cx_i         (cx_q),
    .cy_i         (cy_q),
    .line_start_i (line_start_i),
    .pix_step_i   (pix_valid_i),
    .pix_acc_o    (pix_acc),
    .line_acc_o   (line_acc),
    .dx_o         (dx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_on_q <= 1'b0;
    else         pix_on_q <= pix_valid_i && (pix_acc < rsq_q);
  end

  assign pix_on_o = pix_on_q;
endmodule

// File: rtl/circle_pattern_chk.sv
module circle_pattern_chk #(
  parameter int COORD_W = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  frame_start_i,
  input logic                  line_start_i,
  input logic                  pix_valid_i,
  input logic                  pix_on_o,
  input logic [2*COORD_W+1:0]  rsq_q,
  input logic                  setup_q,
  input logic [2*COORD_W+1:0]  pix_acc,
  input logic [2*COORD_W+1:0]  line_acc,
  input logic signed [COORD_W+1:0] dx
);
  // R2
  idle_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !pix_on_o);

  // R3
  zero_radius_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && rsq_q == '0) |=> !pix_on_o);

  // R4
  param_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(rsq_q));

  // R5
  line_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !setup_q && !frame_start_i) |=> (pix_acc == line_acc));

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !line_start_i && !frame_start_i && !dx[COORD_W+1])
      |=> (pix_acc > $past(pix_acc)));

  // R8
  setup_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_q |-> (!line_start_i && !pix_valid_i));
endmodule

bind circle_pattern_gen circle_pattern_chk #(.COORD_W(COORD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .line_start_i  (line_start_i),
  .pix_valid_i   (pix_valid_i),
  .pix_on_o      (pix_on_o),
  .rsq_q         (rsq_q),
  .setup_q       (setup_q),
  .pix_acc       (pix_acc),
  .line_acc      (line_acc),
  .dx            (dx)
);

// File: tb/circle_pattern_gen_tb.sv
module circle_pattern_gen_tb;
  localparam int CW    = 10;
  localparam int AW    = 2 * CW + 2;
  localparam int SCR_W = 24;
  localparam int SCR_H = 16;
  localparam int NVEC  = 8;

  // centre x, centre y, squared radius
  localparam int VEC [NVEC][3] = '{
    '{10,   8,    25},
    '{0,    0,    50},
    '{23,   15,   100},
    '{12,   7,    1},
    '{5,    3,    0},
    '{40,   30,   1200},
    '{1023, 1023, 4194303},
    '{3,    12,   17}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic          line_start = 1'b0;
  logic          pix_valid = 1'b0;
  logic [CW-1:0] cx = '0;
  logic [CW-1:0] cy = '0;
  logic [AW-1:0] rsq = '0;
  logic          pix_on;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  circle_pattern_gen #(.COORD_W(CW)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .frame_start_i (frame_start),
    .line_start_i  (line_start),
    .pix_valid_i   (pix_valid),
    .cx_i          (cx),
    .cy_i          (cy),
    .rsq_i         (rsq),
    .pix_on_o      (pix_on)
  );

  function automatic bit inside_ref(int x, int y, int ccx, int ccy, int r2);
    int d;
    d = (x - ccx) * (x - ccx) + (y - ccy) * (y - ccy);
    return d < r2;
  endfunction

  task automatic check(logic got, logic exp, string req, int x, int y);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pixel (%0d,%0d): actual %0b expected %0b", req, x, y, got, exp);
    end
  endtask

  task automatic set_params(int a, int b, int c);
    cx  = CW'(a);
    cy  = CW'(b);
    rsq = AW'(c);
  endtask

  // drives one frame; expectations use (ecx,ecy,ersq)
  task automatic run_frame(int ecx, int ecy, int ersq, string req, int lines,
                           bit swap, int scx, int scy, int srsq);
    @(negedge clk);
    set_params(ecx, ecy, ersq);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (swap) set_params(scx, scy, srsq); // R4: late change must be ignored
    repeat (CW + 4) @(negedge clk);
    for (int y = 0; y < lines; y++) begin
      @(negedge clk);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      for (int x = 0; x <= SCR_W; x++) begin
        @(negedge clk);
        if (x > 0) check(pix_on, inside_ref(x - 1, y, ecx, ecy, ersq), req, x - 1, y);
        pix_valid = (x < SCR_W);
      end
      @(negedge clk);
      check(pix_on, 1'b0, "R2 idle", SCR_W, y);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pix_on, 1'b0, "R7 in reset", 0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(pix_on, 1'b0, "R7 after release", 0, 0);

    for (int i = 0; i < NVEC; i++)
      run_frame(VEC[i][0], VEC[i][1], VEC[i][2], "R1 R3 R5 R6", SCR_H, 1'b0, 0, 0, 0);

    // R4: inputs moved right after frame start
    run_frame(10, 8, 25, "R4 held", SCR_H, 1'b1, 2, 2, 400);
    run_frame(2, 2, 400, "R4 next frame", SCR_H, 1'b0, 0, 0, 0);

    // R8: abandon a frame partway, restart with new parameters
    run_frame(20, 4, 60, "R8 partial", 5, 1'b0, 0, 0, 0);
    run_frame(6, 10, 30, "R8 restart", SCR_H, 1'b0, 0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule